// File: doc/BRIEF.md
# Check-Stop Control Logic

This block chooses how the processor reacts when hardware reports an error. An operator control selects one of two modes. In stop mode, an uncorrected machine check freezes the processor in a check-stop state. A channel check that needs logout data written to storage does the same. In normal mode, both kinds of error go on as one-cycle strobes to the ordinary machine-check and I/O interruption paths.

The check-stop state is sticky. Only reset clears it. While it holds, new error strobes have no effect and no forwarding strobes leave the block. The block also drives two panel lamps. The test lamp is lit whenever the control is at stop. The check-stop lamp is lit while the processor is check-stopped.

Channel checks come in on `CHANNELS` independent lanes, each with its own logout-required flag.

Top module: `ckstop_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release with no strobes, `halted_o`, `halt_lamp_o`, `fwd_mck_o` and every bit of `fwd_chan_o` are 0.
- R2: With `ctl_stop_i`=1 (1 = stop, 0 = normal) and the block not halted, a high `mck_uncorr_i` sets `halted_o` at the next clock edge.
- R3: With `ctl_stop_i`=1 and the block not halted, any lane i with both `chan_chk_i[i]` and `chan_logout_i[i]` high sets `halted_o` at the next clock edge.
- R4: `test_lamp_o` equals `ctl_stop_i` in every cycle, combinationally.
- R5: Once set, `halted_o` stays 1 until reset, whatever the control or strobes do. `halt_lamp_o` always equals `halted_o`.
- R6: With `ctl_stop_i`=0 and the block not halted, `mck_uncorr_i` gives `fwd_mck_o`=1 and `chan_chk_i[i]` gives `fwd_chan_o[i]`=1, each for exactly the following cycle. The logout flag makes no difference in this mode.
- R7: With `ctl_stop_i`=1, a lane whose check comes without logout is forwarded on `fwd_chan_o[i]` in the following cycle. This holds provided the block is not halted and does not enter check-stop in that same cycle.
- R8: In a cycle where the block is halted, or where it enters check-stop, no strobe is forwarded. Both forwarding outputs are 0 in the following cycle.
- R9: When reset is asserted in the same cycle as any error strobe, reset wins. `halted_o` and all forwarding outputs are 0 after reset is released.
- R10: Lanes are independent. Forwarding on `fwd_chan_o[i]` depends only on lane i's inputs, apart from the shared halt and entry gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_stop_i | input | 1 | Check control: 1 = stop, 0 = normal |
| mck_uncorr_i | input | 1 | Uncorrected machine-check strobe |
| chan_chk_i | input | CHANNELS | Channel-check strobe per lane |
| chan_logout_i | input | CHANNELS | Logout-required flag per lane, valid with its strobe |
| halted_o | output | 1 | Check-stop state |
| halt_lamp_o | output | 1 | Check-stop panel indicator |
| test_lamp_o | output | 1 | Test panel indicator |
| fwd_mck_o | output | 1 | Machine-check strobe forwarded to interruption handling |
| fwd_chan_o | output | CHANNELS | Channel-check strobes forwarded to I/O handling |

## Verification
The bench goes after four cases:
- **Channel check without logout in stop mode.** A design that treats every channel check as fatal would freeze here instead of forwarding.
- **A no-logout lane and a stop-causing event in the same cycle.** A design that forwarded this lane would let an interrupt escape as the processor stops.
- **Strobes after the stop.** A design that did not gate on the held state would keep emitting them.
- **Reset together with a strobe.** A design that let the strobe win would come out of reset already check-stopped.

Random traffic also flips the control while the block is halted. This exposes a state that wrongly follows the control rather than holding until reset.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;

  typedef enum logic {
    CTL_NORMAL = 1'b0,
    CTL_STOP   = 1'b1
  } ctl_mode_e;

  // A fatal event under stop mode moves a running CPU into check-stop.
  function automatic logic halt_trigger(input logic halted, input ctl_mode_e mode,
                                        input logic mck, input logic any_logout_chk);
    return !halted && (mode == CTL_STOP) && (mck || any_logout_chk);
  endfunction

  // Forwarding is allowed only while running and not entering the stop.
  function automatic logic may_forward(input logic halted, input logic entering);
    return !halted && !entering;
  endfunction

endpackage

// File: rtl/ckstop_classify.sv
module ckstop_classify #(
  parameter int CHANNELS = 4
) (
  input  logic                halted,
  input  logic                ctl_stop,
  input  logic                mck,
  input  logic [CHANNELS-1:0] chan,
  input  logic [CHANNELS-1:0] logout,
  output logic                enter,
  output logic                mck_req,
  output logic [CHANNELS-1:0] chan_req
);
  import ckstop_pkg::*;

  logic [CHANNELS-1:0] fatal_lane;
  logic                any_fatal;
  logic                pass_ok;
  ctl_mode_e           mode;

  assign mode = ctl_mode_e'(ctl_stop);

  for (genvar i = 0; i < CHANNELS; i++) begin : g_lane
    assign fatal_lane[i] = chan[i] && logout[i];
    assign chan_req[i]   = pass_ok && chan[i];
  end

  assign any_fatal = |fatal_lane;
  assign enter     = halt_trigger(halted, mode, mck, any_fatal);
  assign pass_ok   = may_forward(halted, enter);
  assign mck_req   = pass_ok && mck;

endmodule

// File: rtl/ckstop_hold.sv
module ckstop_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  output logic halted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     halted <= 1'b0;
    else if (enter) halted <= 1'b1;
  end
endmodule

// File: rtl/ckstop_fwd.sv
module ckstop_fwd #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] strobe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe[i] <= 1'b0;
      else        strobe[i] <= req[i];
    end
  end
endmodule

// File: rtl/ckstop_ctrl.sv
module ckstop_ctrl #(
  parameter int CHANNELS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_stop_i,
  input  logic                mck_uncorr_i,
  input  logic [CHANNELS-1:0] chan_chk_i,
  input  logic [CHANNELS-1:0] chan_logout_i,
  output logic                halted_o,
  output logic                halt_lamp_o,
  output logic                test_lamp_o,
  output logic                fwd_mck_o,
  output logic [CHANNELS-1:0] fwd_chan_o
);
  logic                halted_w;
  logic                enter_w;
  logic                mck_req_w;
  logic [CHANNELS-1:0] chan_req_w;

  ckstop_classify #(.CHANNELS(CHANNELS)) u_class (
    .halted   (halted_w),
    .ctl_stop (ctl_stop_i),
    .mck      (mck_uncorr_i),
    .chan     (chan_chk_i),
    .logout   (chan_logout_i),
    .enter    (enter_w),
    .mck_req  (mck_req_w),
    .chan_req (chan_req_w)
  );

  ckstop_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .enter  (enter_w),
    .halted (halted_w)
  );

  ckstop_fwd #(.WIDTH(1)) u_fwd_mck (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (mck_req_w),
    .strobe (fwd_mck_o)
  );

  ckstop_fwd #(.WIDTH(CHANNELS)) u_fwd_chan (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (chan_req_w),
    .strobe (fwd_chan_o)
  );

  assign halted_o    = halted_w;
  assign halt_lamp_o = halted_w;
  assign test_lamp_o = ctl_stop_i;

endmodule

// File: rtl/ckstop_ctrl_chk.sv
module ckstop_ctrl_chk #(
  parameter int CHANNELS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctl_stop_i,
  input logic                mck_uncorr_i,
  input logic [CHANNELS-1:0] chan_chk_i,
  input logic [CHANNELS-1:0] chan_logout_i,
  input logic                halted_o,
  input logic                halt_lamp_o,
  input logic                test_lamp_o,
  input logic                fwd_mck_o,
  input logic [CHANNELS-1:0] fwd_chan_o,
  input logic                enter_w
);
  AST_MCK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_stop_i && mck_uncorr_i && !halted_o) |=> halted_o); // R2

  AST_LOGOUT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_stop_i && |(chan_chk_i & chan_logout_i) && !halted_o) |=> halted_o); // R3

  AST_TEST_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
    test_lamp_o == ctl_stop_i); // R4

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o); // R5

  AST_HALT_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
    halt_lamp_o == halted_o); // R5

  AST_MCK_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_stop_i && mck_uncorr_i && !halted_o) |=> fwd_mck_o); // R6

  AST_QUIET_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o || enter_w) |=> (!fwd_mck_o && fwd_chan_o == '0)); // R8

  for (genvar i = 0; i < CHANNELS; i++) begin : g_lane_chk
    AST_NOLOG_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_chk_i[i] && !chan_logout_i[i] && !halted_o && !enter_w) |=> fwd_chan_o[i]); // R7
    AST_LANE_ONLY_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_chk_i[i] |=> !fwd_chan_o[i]); // R10
  end
endmodule

bind ckstop_ctrl ckstop_ctrl_chk #(.CHANNELS(CHANNELS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_stop_i    (ctl_stop_i),
  .mck_uncorr_i  (mck_uncorr_i),
  .chan_chk_i    (chan_chk_i),
  .chan_logout_i (chan_logout_i),
  .halted_o      (halted_o),
  .halt_lamp_o   (halt_lamp_o),
  .test_lamp_o   (test_lamp_o),
  .fwd_mck_o     (fwd_mck_o),
  .fwd_chan_o    (fwd_chan_o),
  .enter_w       (enter_w)
);

// File: tb/ckstop_ctrl_test.sv
`timescale 1ns/1ps
module ckstop_ctrl_test;
  localparam int CH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_stop_i = 1'b0;
  logic          mck_uncorr_i = 1'b0;
  logic [CH-1:0] chan_chk_i = '0;
  logic [CH-1:0] chan_logout_i = '0;
  logic          halted_o, halt_lamp_o, test_lamp_o, fwd_mck_o;
  logic [CH-1:0] fwd_chan_o;

  int checks = 0;
  int errors = 0;
  logic exp_h = 1'b0;

  always #2.5 clk = ~clk;

  ckstop_ctrl #(.CHANNELS(CH)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_stop_i(ctl_stop_i), .mck_uncorr_i(mck_uncorr_i),
    .chan_chk_i(chan_chk_i), .chan_logout_i(chan_logout_i), .halted_o(halted_o),
    .halt_lamp_o(halt_lamp_o), .test_lamp_o(test_lamp_o), .fwd_mck_o(fwd_mck_o),
    .fwd_chan_o(fwd_chan_o)
  );

  function automatic logic model_enter(input logic h, input logic s, input logic m,
                                       input logic [CH-1:0] c, input logic [CH-1:0] l);
    if (h || !s) return 1'b0;
    return m || ((c & l) != '0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic m,
                      input logic [CH-1:0] c, input logic [CH-1:0] l);
    logic ent, pass;
    logic [CH-1:0] ef;
    string ht;
    @(negedge clk);
    rst_n = r; ctl_stop_i = s; mck_uncorr_i = m; chan_chk_i = c; chan_logout_i = l;
    #1;
    check("R4 test lamp", 32'(test_lamp_o), 32'(s));
    ent  = model_enter(exp_h, s, m, c, l);
    pass = !exp_h && !ent;
    ef   = pass ? c : '0;
    ht   = ent ? ((s && m) ? "R2" : "R3") : "R5";
    @(posedge clk); #1;
    if (!r) begin
      exp_h = 1'b0;
      check((m || c != '0) ? "R9 reset wins halted" : "R1 reset halted", 32'(halted_o), 0);
      check("R1 reset fwd_mck", 32'(fwd_mck_o), 0);
      check("R9 reset fwd_chan", 32'(fwd_chan_o), 0);
    end else begin
      check({ht, " halted"}, 32'(halted_o), 32'(exp_h || ent));
      check((exp_h || ent) ? "R8 fwd_mck" : "R6 fwd_mck", 32'(fwd_mck_o), 32'(pass && m));
      check((exp_h || ent) ? "R8 fwd_chan" : (s ? "R7 fwd_chan" : "R6 fwd_chan"),
            32'(fwd_chan_o), 32'(ef));
      exp_h = exp_h || ent;
    end
    check("R5 halt lamp", 32'(halt_lamp_o), 32'(halted_o));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4817));
    // R1: reset state
    step(0, 0, 0, '0, '0);
    step(1, 0, 0, '0, '0);
    // R9: reset in same cycle as fatal strobes
    step(0, 1, 1, 4'b0011, 4'b0011);
    step(1, 0, 0, '0, '0);
    check("R9 post-reset halted", 32'(halted_o), 0);
    // R6: normal forwarding, logout ignored
    step(1, 0, 1, 4'b0101, 4'b0100);
    step(1, 0, 0, '0, '0);
    // R10: single lane isolation
    step(1, 0, 0, 4'b1000, 4'b0000);
    check("R10 only lane 3", 32'(fwd_chan_o), 32'h8);
    // R7: no-logout lane in stop mode forwarded
    step(1, 1, 0, 4'b0010, 4'b0000);
    // R8: no-logout lane alongside fatal lane is suppressed (enters R3)
    step(1, 1, 0, 4'b0110, 4'b0100);
    // R5/R8: sticky, control flips, strobes ignored
    step(1, 0, 1, 4'b1111, 4'b0000);
    step(1, 1, 1, 4'b1111, 4'b1111);
    step(1, 0, 0, '0, '0);
    step(0, 0, 0, '0, '0);
    step(1, 0, 0, '0, '0);
    // R2: machine check in stop mode
    step(1, 1, 1, '0, '0);
    step(1, 1, 0, 4'b0001, 4'b0000);
    step(0, 1, 0, '0, '0);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic r, s, m;
      logic [CH-1:0] c, l;
      r = ($urandom_range(0, 39) != 0);
      s = ($urandom_range(0, 2) != 0);
      m = ($urandom_range(0, 11) == 0);
      c = '0; l = '0;
      for (int k = 0; k < CH; k++) begin
        c[k] = ($urandom_range(0, 4) == 0);
        l[k] = ($urandom_range(0, 3) == 0);
      end
      step(r, s, m, c, l);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule